// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog peripheral that counts down on its own watchdog clock. Software reaches it through a small register bus on a separate bus clock. It restarts the count only when it sees a two-word unlock pattern, 0xAA and then 0x55, on the feed register. It also refuses a restart while the count is still above a programmable window limit. When the count falls to a programmable compare value it raises a warning interrupt. When the count reaches zero, or when a restart comes too early, it can raise a single-cycle reset pulse.

The enable and reset-enable mode bits can be written at any time, but they only reach the counter on a completed feed. Configuration travels from the bus clock to the watchdog clock through a toggle handshake. The count travels back through a continuous snapshot loop.

The bus uses a valid/ready handshake and completes a transfer on a clock edge where `bus_valid` and `bus_ready` are both high. Read data is valid during that cycle. `bus_ready` drops for every transfer while a configuration crossing is still unacknowledged. A master must hold its request, address and write data stable until it is accepted.

Top module: `wwd_top`

## Requirements
- R1: After reset the registers read as follows: mode (offset 0x00) reads 0, constant (0x04) reads 0xFF, value (0x0C) reads 0xFF, warning compare (0x14) reads 0, window (0x18) reads 0xFFFFFF. The write-only feed register (0x08) reads 0.
- R2: A write of 0xAA and then a write of 0x55 to the feed register is a completed feed. A completed feed loads the counter with the constant register. While enabled, the counter then falls by one on each watchdog clock.
- R3: Any feed write other than 0x55 directly after 0xAA cancels the sequence. A canceled sequence does not reload the counter, and a new sequence must begin with 0xAA.
- R4: Mode bit 0 is enable and bit 1 is reset-enable. Written values read back at once but do not affect the counter until a completed feed.
- R5: When the counter steps down onto the warning compare value, mode bit 3 sets and `irq_o` goes high. Writing 1 to bit 3 clears both.
- R6: When the counter reaches zero while enabled, it stays at zero and mode bit 2 (time-out) sets. If reset-enable is active, `wd_rst_o` pulses high for exactly one watchdog clock; otherwise it stays low. Writing 1 to bit 2 clears the flag.
- R7: A completed feed while enabled and while the count is above the window value does not reload the counter. With reset-enable active, such a feed also pulses `wd_rst_o` and sets the time-out flag. A feed at or below the window value reloads normally.
- R8: A write to the constant, warning compare or window register, or the final word of a completed feed, holds `bus_ready` low from the next bus clock until the watchdog domain has taken the new values. The new values take effect at the third watchdog clock edge.
- R9: The value register returns a snapshot of the counter that was carried across into the bus clock domain. Once the counter has stopped, the value register returns the exact count.
- R10: While enable is off, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| wd_clk | input | 1 | Watchdog counting clock |
| wd_rst_n | input | 1 | Asynchronous active-low reset, watchdog domain |
| bus_valid | input | 1 | Bus request valid |
| bus_ready | output | 1 | Bus request accepted when high together with valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the handshake cycle |
| irq_o | output | 1 | Warning interrupt, level |
| wd_rst_o | output | 1 | Reset request pulse, watchdog domain |

## Verification
The hardest case to reach from the ports is a feed that arrives while the counter is running but still above the window. A second case is a feed that lands inside the window before the counter runs out. Both depend on the counter position at the moment the crossing delivers the feed. The stimulus feeds once to start the count, then feeds again as soon as `bus_ready` returns, so the count is still near the constant. It then waits a number of watchdog clocks chosen to fall in the middle of the legal span for a third feed. The remaining checks use the counter when it is stopped, either disabled or at zero, so the value register can be compared exactly.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_TC   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_FEED = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_VAL  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_WARN = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_WIN  = 5'h18;

  localparam int MB_EN    = 0;
  localparam int MB_RSTEN = 1;
  localparam int MB_TOUT  = 2;
  localparam int MB_WARN  = 3;

  localparam logic [7:0] FEED_KEY1 = 8'hAA;
  localparam logic [7:0] FEED_KEY2 = 8'h55;

  typedef enum logic {FD_IDLE, FD_ARMED} feed_st_e;
endpackage

// File: rtl/wwd_sync.sv
module wwd_sync #(
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  generate
    if (EDGE) begin : g_edge
      assign q_o = chain[STAGES-1] ^ chain[STAGES-2];
    end else begin : g_level
      assign q_o = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  // toward watchdog domain
  output logic              req_tgl_o,
  output logic              feed_o,
  output logic              en_o,
  output logic              rsten_o,
  output logic [CNT_W-1:0]  tc_o,
  output logic [CNT_W-1:0]  win_o,
  output logic [CNT_W-1:0]  wcmp_o,
  input  logic              ack_i,
  // from watchdog domain
  input  logic              tout_ev_i,
  input  logic              warn_ev_i,
  input  logic              snap_ev_i,
  input  logic [CNT_W-1:0]  snap_i,
  output logic              snap_ack_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] TC_RST  = CNT_W'(8'hFF);
  localparam logic [CNT_W-1:0] WIN_RST = '1;

  feed_st_e          feed_st;
  logic              en_p, rsten_p, en_a, rsten_a;
  logic              tout_f, warn_f;
  logic [CNT_W-1:0]  tc_q, win_q, wcmp_q, val_q;
  logic              req_q, feed_q, sack_q;
  logic              wr;

  assign ready_o = (req_q == ack_i);
  assign wr      = valid_i & ready_o & write_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feed_st <= FD_IDLE;
      en_p    <= 1'b0;
      rsten_p <= 1'b0;
      en_a    <= 1'b0;
      rsten_a <= 1'b0;
      tout_f  <= 1'b0;
      warn_f  <= 1'b0;
      tc_q    <= TC_RST;
      win_q   <= WIN_RST;
      wcmp_q  <= '0;
      val_q   <= TC_RST;
      req_q   <= 1'b0;
      feed_q  <= 1'b0;
      sack_q  <= 1'b0;
    end else begin
      if (wr) begin
        case (addr_i)
          OFS_MODE: begin
            en_p    <= wdata_i[MB_EN];
            rsten_p <= wdata_i[MB_RSTEN];
            if (wdata_i[MB_TOUT]) tout_f <= 1'b0;
            if (wdata_i[MB_WARN]) warn_f <= 1'b0;
          end
          OFS_TC: begin
            tc_q   <= wdata_i[CNT_W-1:0];
            feed_q <= 1'b0;
            req_q  <= ~req_q;
          end
          OFS_WARN: begin
            wcmp_q <= wdata_i[CNT_W-1:0];
            feed_q <= 1'b0;
            req_q  <= ~req_q;
          end
          OFS_WIN: begin
            win_q  <= wdata_i[CNT_W-1:0];
            feed_q <= 1'b0;
            req_q  <= ~req_q;
          end
          OFS_FEED: begin
            if (feed_st == FD_ARMED && wdata_i == DATA_W'(FEED_KEY2)) begin
              feed_st <= FD_IDLE;
              en_a    <= en_p;
              rsten_a <= rsten_p;
              feed_q  <= 1'b1;
              req_q   <= ~req_q;
            end else if (wdata_i == DATA_W'(FEED_KEY1)) begin
              feed_st <= FD_ARMED;
            end else begin
              feed_st <= FD_IDLE;
            end
          end
          default: ;
        endcase
      end
      // flag sets from the counting domain win over a same-cycle clear
      if (tout_ev_i) tout_f <= 1'b1;
      if (warn_ev_i) warn_f <= 1'b1;
      if (snap_ev_i) begin
        val_q  <= snap_i;
        sack_q <= ~sack_q;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_MODE: begin
        rdata_o[MB_EN]    = en_p;
        rdata_o[MB_RSTEN] = rsten_p;
        rdata_o[MB_TOUT]  = tout_f;
        rdata_o[MB_WARN]  = warn_f;
      end
      OFS_TC:   rdata_o = DATA_W'(tc_q);
      OFS_VAL:  rdata_o = DATA_W'(val_q);
      OFS_WARN: rdata_o = DATA_W'(wcmp_q);
      OFS_WIN:  rdata_o = DATA_W'(win_q);
      default:  rdata_o = '0;
    endcase
  end

  assign req_tgl_o  = req_q;
  assign feed_o     = feed_q;
  assign en_o       = en_a;
  assign rsten_o    = rsten_a;
  assign tc_o       = tc_q;
  assign win_o      = win_q;
  assign wcmp_o     = wcmp_q;
  assign snap_ack_o = sack_q;
  assign irq_o      = warn_f;
endmodule

// File: rtl/wwd_core.sv
module wwd_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             feed_i,
  input  logic             en_i,
  input  logic             rsten_i,
  input  logic [CNT_W-1:0] tc_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic [CNT_W-1:0] wcmp_i,
  output logic             ack_tgl_o,
  input  logic             snap_ack_i,
  output logic             snap_tgl_o,
  output logic [CNT_W-1:0] snap_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             rsten_o,
  output logic             tout_tgl_o,
  output logic             warn_tgl_o,
  output logic             rst_o
);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(8'hFF);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, win_q, wcmp_q, snap_q;
  logic             en_q, rsten_q, ack_q, snap_tgl_q, tout_tgl_q, warn_tgl_q, rst_q;
  logic             feed_now, feed_err, reload, dec, hit_zero, hit_warn, fire;

  always_comb begin
    feed_now = cap_i & feed_i;
    feed_err = feed_now & en_q & (cnt_q > win_q);
    reload   = feed_now & ~feed_err;
    dec      = en_q & (cnt_q != '0) & ~reload;
    hit_zero = dec & (cnt_q == ONE);
    hit_warn = dec & ((cnt_q - ONE) == wcmp_q);
    fire     = (hit_zero | feed_err) & rsten_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= CNT_RST;
      win_q      <= '1;
      wcmp_q     <= '0;
      en_q       <= 1'b0;
      rsten_q    <= 1'b0;
      ack_q      <= 1'b0;
      snap_q     <= CNT_RST;
      snap_tgl_q <= 1'b0;
      tout_tgl_q <= 1'b0;
      warn_tgl_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      if (cap_i) begin
        win_q   <= win_i;
        wcmp_q  <= wcmp_i;
        en_q    <= en_i;
        rsten_q <= rsten_i;
        ack_q   <= ~ack_q;
      end
      if (reload)   cnt_q <= tc_i;
      else if (dec) cnt_q <= cnt_q - ONE;

      if (hit_zero | (feed_err & rsten_q)) tout_tgl_q <= ~tout_tgl_q;
      if (hit_warn)                        warn_tgl_q <= ~warn_tgl_q;
      rst_q <= fire & ~rst_q;

      if (snap_ack_i == snap_tgl_q) begin
        snap_q     <= cnt_q;
        snap_tgl_q <= ~snap_tgl_q;
      end
    end
  end

  assign ack_tgl_o  = ack_q;
  assign snap_tgl_o = snap_tgl_q;
  assign snap_o     = snap_q;
  assign cnt_o      = cnt_q;
  assign en_o       = en_q;
  assign rsten_o    = rsten_q;
  assign tout_tgl_o = tout_tgl_q;
  assign warn_tgl_o = warn_tgl_q;
  assign rst_o      = rst_q;
endmodule

// File: rtl/wwd_top.sv
module wwd_top
  import wwd_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              wd_clk,
  input  logic              wd_rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wd_rst_o
);
  localparam int EDGE_N = SYNC_N + 1;

  logic             req_tgl, feed_b, en_b, rsten_b, cfg_ack;
  logic [CNT_W-1:0] tc_b, win_b, wcmp_b;
  logic             tout_ev, warn_ev, snap_ev, snap_ack_b;
  logic             wd_cap, wd_ack_tgl, wd_snap_tgl, wd_snap_ack;
  logic             wd_tout_tgl, wd_warn_tgl, wd_en, wd_rsten;
  logic [CNT_W-1:0] wd_snap, wd_cnt;

  wwd_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(bus_clk), .rst_n(bus_rst_n),
    .valid_i(bus_valid), .ready_o(bus_ready), .write_i(bus_write),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .req_tgl_o(req_tgl), .feed_o(feed_b), .en_o(en_b), .rsten_o(rsten_b),
    .tc_o(tc_b), .win_o(win_b), .wcmp_o(wcmp_b), .ack_i(cfg_ack),
    .tout_ev_i(tout_ev), .warn_ev_i(warn_ev), .snap_ev_i(snap_ev),
    .snap_i(wd_snap), .snap_ack_o(snap_ack_b), .irq_o(irq_o)
  );

  wwd_sync #(.STAGES(EDGE_N), .EDGE(1'b1)) u_s_req (
    .clk(wd_clk), .rst_n(wd_rst_n), .d_i(req_tgl), .q_o(wd_cap));
  wwd_sync #(.STAGES(SYNC_N), .EDGE(1'b0)) u_s_cack (
    .clk(bus_clk), .rst_n(bus_rst_n), .d_i(wd_ack_tgl), .q_o(cfg_ack));
  wwd_sync #(.STAGES(EDGE_N), .EDGE(1'b1)) u_s_tout (
    .clk(bus_clk), .rst_n(bus_rst_n), .d_i(wd_tout_tgl), .q_o(tout_ev));
  wwd_sync #(.STAGES(EDGE_N), .EDGE(1'b1)) u_s_warn (
    .clk(bus_clk), .rst_n(bus_rst_n), .d_i(wd_warn_tgl), .q_o(warn_ev));
  wwd_sync #(.STAGES(EDGE_N), .EDGE(1'b1)) u_s_snap (
    .clk(bus_clk), .rst_n(bus_rst_n), .d_i(wd_snap_tgl), .q_o(snap_ev));
  wwd_sync #(.STAGES(SYNC_N), .EDGE(1'b0)) u_s_sack (
    .clk(wd_clk), .rst_n(wd_rst_n), .d_i(snap_ack_b), .q_o(wd_snap_ack));

  wwd_core #(.CNT_W(CNT_W)) u_core (
    .clk(wd_clk), .rst_n(wd_rst_n),
    .cap_i(wd_cap), .feed_i(feed_b), .en_i(en_b), .rsten_i(rsten_b),
    .tc_i(tc_b), .win_i(win_b), .wcmp_i(wcmp_b), .ack_tgl_o(wd_ack_tgl),
    .snap_ack_i(wd_snap_ack), .snap_tgl_o(wd_snap_tgl), .snap_o(wd_snap),
    .cnt_o(wd_cnt), .en_o(wd_en), .rsten_o(wd_rsten),
    .tout_tgl_o(wd_tout_tgl), .warn_tgl_o(wd_warn_tgl), .rst_o(wd_rst_o)
  );
endmodule

// File: rtl/wwd_chk.sv
module wwd_chk
  import wwd_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic              wd_clk,
  input logic              wd_rst_n,
  input logic [CNT_W-1:0]  cnt,
  input logic              en,
  input logic              rsten,
  input logic              cap,
  input logic              rst_pulse,
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr
);
  AST_CNT_STEP: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (en && cnt != '0 && !cap) |=> (cnt == $past(cnt) - CNT_W'(1))); // R2
  AST_CNT_HOLD_OFF: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (!en && !cap) |=> $stable(cnt)); // R10
  AST_ZERO_STICKY: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (cnt == '0 && !cap) |=> (cnt == '0)); // R6
  AST_RST_ONE_CYCLE: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    rst_pulse |=> !rst_pulse); // R6
  AST_RST_NEEDS_RSTEN: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    rst_pulse |-> $past(rsten)); // R7
  AST_CFG_STALL: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (bus_valid && bus_ready && bus_write &&
     (bus_addr == OFS_TC || bus_addr == OFS_WARN || bus_addr == OFS_WIN)) |=> !bus_ready); // R8
endmodule

bind wwd_top wwd_chk #(.CNT_W(CNT_W)) u_chk (
  .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .cnt(wd_cnt), .en(wd_en),
  .rsten(wd_rsten), .cap(wd_cap), .rst_pulse(wd_rst_o),
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_write(bus_write), .bus_addr(bus_addr)
);

// File: tb/sim_wwd_top.sv
module sim_wwd_top;
  logic        bus_clk = 1'b0, wd_clk = 1'b0;
  logic        bus_rst_n = 1'b0, wd_rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, irq_o, wd_rst_o;
  logic [31:0] bus_rdata;

  int n_chk = 0, n_bad = 0;
  int pulses = 0, run = 0, max_run = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4  bus_clk = ~bus_clk;
  always #10 wd_clk  = ~wd_clk;

  wwd_top u0 (.*);

  // scoreboard monitor: pops an expected read value at each read handshake
  always @(negedge bus_clk) begin
    if (bus_valid && bus_ready && !bus_write && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: read 0x%0h expected 0x%0h", t, bus_rdata, e);
      end
    end
  end

  // reset pulse monitor
  always @(negedge wd_clk) begin
    if (wd_rst_o) begin
      run++;
      if (run > max_run) max_run = run;
      if (run == 1) pulses++;
    end else run = 0;
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", t, act, e);
    end
  endtask

  task automatic bus_xfer(input logic w, input logic [4:0] a, input logic [31:0] d);
    @(posedge bus_clk); #2;
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    while (!bus_ready) @(negedge bus_clk);
    @(posedge bus_clk); #2;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_xfer(1'b0, a, 32'h0);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_xfer(1'b1, a, d);
  endtask

  task automatic feed();
    wr(5'h08, 32'hAA);
    wr(5'h08, 32'h55);
  endtask

  task automatic wait_wd(input int n);
    repeat (n) @(posedge wd_clk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100;
    bus_rst_n = 1'b1; wd_rst_n = 1'b1;
    wait_wd(4);
    // R1 reset state
    rd(5'h00, 32'h0, "R1 mode");
    rd(5'h04, 32'hFF, "R1 constant");
    rd(5'h0C, 32'hFF, "R1 value");
    rd(5'h14, 32'h0, "R1 warn");
    rd(5'h18, 32'hFF_FFFF, "R1 window");
    rd(5'h08, 32'h0, "R1 feed reads zero");
    // R8 write to constant stalls the bus
    wr(5'h04, 32'h40);
    @(negedge bus_clk);
    chk("R8 ready low after constant write", {31'b0, bus_ready}, 32'h0);
    rd(5'h04, 32'h40, "R8 constant readback");
    // R4 mode pending until feed
    wr(5'h00, 32'h1);
    rd(5'h00, 32'h1, "R4 mode reads pending bits");
    wait_wd(40);
    rd(5'h0C, 32'hFF, "R4 no count before feed");
    // R3 aborted sequence
    wr(5'h08, 32'hAA); wr(5'h08, 32'h12); wr(5'h08, 32'h55);
    wait_wd(30);
    rd(5'h0C, 32'hFF, "R3 aborted feed does not reload");
    // R2 R5 counting, warning and silent time-out
    wr(5'h14, 32'h20);
    feed();
    wait_wd(40);
    rd(5'h00, 32'h9, "R5 warning set mid count, no time-out yet");
    wait_wd(60);
    rd(5'h00, 32'hD, "R6 time-out and warning flags");
    chk("R5 irq high", {31'b0, irq_o}, 32'h1);
    chk("R6 no pulse without reset-enable", pulses, 0);
    rd(5'h0C, 32'h0, "R9 value reads zero after time-out");
    wr(5'h00, 32'hD);
    rd(5'h00, 32'h1, "R5 flags cleared by write one");
    chk("R5 irq low after clear", {31'b0, irq_o}, 32'h0);
    // R7 window
    wr(5'h14, 32'h0);
    wr(5'h04, 32'h80);
    wr(5'h18, 32'h40);
    wr(5'h00, 32'h3);
    feed();
    feed();
    wait_wd(10);
    chk("R7 early feed pulses reset", pulses, 1);
    rd(5'h00, 32'h7, "R7 early feed sets time-out");
    wr(5'h00, 32'h7);
    rd(5'h00, 32'h3, "R7 flag cleared");
    wait_wd(70);
    feed();
    wait_wd(10);
    chk("R7 in-window feed no pulse", pulses, 1);
    rd(5'h00, 32'h3, "R7 in-window feed no flag");
    // R10 disable and exact reload
    wr(5'h18, 32'hFF_FFFF);
    wr(5'h00, 32'h0);
    feed();
    wait_wd(30);
    rd(5'h0C, 32'h80, "R2 reload value exact");
    wait_wd(100);
    rd(5'h0C, 32'h80, "R10 counter holds while disabled");
    // R6 time-out with reset-enable
    wr(5'h04, 32'h30);
    wr(5'h00, 32'h3);
    feed();
    wait_wd(80);
    chk("R6 time-out pulse", pulses, 2);
    chk("R6 pulse one cycle wide", max_run, 1);
    rd(5'h00, 32'hF, "R6 flags after time-out");
    rd(5'h0C, 32'h0, "R9 value zero");
    chk("R5 irq on warning at zero", {31'b0, irq_o}, 32'h1);
    wait_wd(5);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule